// File: doc/BRIEF.md
# Display Interrupt Control Register

A single 32-bit control and status word for the two display interrupt events, written by a host through sub-word accesses. It tracks the vertical-blank level from the video timing logic as a live status bit. It latches two event flags, one for vertical blank and one for line match, and gates each flag with its own enable bit. The flags feed one level-sensitive interrupt request.

Every bit follows one of three write rules. The live status bit ignores writes. Each flag bit is write-one-to-acknowledge: a 1 written to it clears it, and a 0 leaves it alone. All remaining bits are plain storage. A host write carries a byte offset and a byte count. Its data sits in the low bits of the data bus and is placed into the word at byte lane `offset`. Only the lanes actually written take part in the update. An access that does not fit inside the word is dropped and reported with a one-cycle error pulse.

Top module: `disp_irq_reg`

## Requirements
- R1: Bit 0 of `rd_data_o` equals `vblank_i` as sampled at the previous clock edge; host writes never change it.
- R2: While `vblank_i` is high at a clock edge, both flag bits (bit 2 vertical-blank flag, bit 4 line-match flag) are 1 after that edge, even if the same edge carries an acknowledge write to them.
- R3: A legal write with a 1 in bit 2 or bit 4, inside a written byte lane, clears that flag. A 0 there, or a lane not written, leaves the flag unchanged.
- R4: Bit 1 (vertical-blank enable), bit 3 (line-match enable) and bits 31:5 store the written value exactly.
- R5: A write of `wr_size_i` bytes (1, 2 or 4) at byte offset `wr_off_i` takes its data from `wr_data_i` bits [8*size-1:0]. It updates only bytes `wr_off_i` to `wr_off_i`+size-1 of the word and leaves the other bytes as they were.
- R6: `irq_o` is 1 in the cycle after the register held (bit 2 AND bit 1) OR (bit 4 AND bit 3); with both enables 0 it stays low.
- R7: A write whose size is not 1, 2 or 4, or whose offset plus size exceeds 4, changes no bit, and `wr_err_o` is high for exactly the following cycle.
- R8: After reset the word reads 0 and `irq_o` and `wr_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one cycle per access |
| wr_off_i | input | 2 | Byte offset of the access |
| wr_size_i | input | 3 | Byte count of the access |
| wr_data_i | input | 32 | Write data, low-aligned |
| vblank_i | input | 1 | Vertical-blank level from video timing |
| rd_data_o | output | 32 | Current register word |
| irq_o | output | 1 | Interrupt request, level |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
An acknowledge write and a hardware vertical-blank set can target the same flag at the same edge. The bench provokes this on purpose by raising `vblank_i` in the cycle that writes 1 to both flag bits. It also lets random stimulus line the two up many more times. A behavioural model applies the rule that the set wins, and the bench compares the full word, the interrupt and the error pulse after every edge. Narrow acknowledges into a lane other than the flag lane are mixed in as well, so that a flag cleared by a write that never reached its byte shows up as a mismatch.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned BYTES  = REG_W / 8;
  localparam int unsigned OFF_W  = $clog2(BYTES);
  localparam int unsigned SIZE_W = OFF_W + 1;

  localparam int unsigned LIVE_B   = 0;
  localparam int unsigned VB_EN_B  = 1;
  localparam int unsigned VB_FLG_B = 2;
  localparam int unsigned VL_EN_B  = 3;
  localparam int unsigned VL_FLG_B = 4;

  localparam logic [REG_W-1:0] RO_MASK  = REG_W'(1) << LIVE_B;
  localparam logic [REG_W-1:0] ACK_MASK = (REG_W'(1) << VB_FLG_B) | (REG_W'(1) << VL_FLG_B);
endpackage

// File: rtl/disp_irq_merge.sv
module disp_irq_merge
  import disp_irq_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [REG_W-1:0]  data_i,
  output logic              legal_o,
  output logic [REG_W-1:0]  bit_mask_o,
  output logic [REG_W-1:0]  bits_o
);
  logic [SIZE_W:0] end_pos;

  assign end_pos = (SIZE_W+1)'(off_i) + (SIZE_W+1)'(size_i);
  assign legal_o = $onehot(size_i) && (end_pos <= (SIZE_W+1)'(BYTES));
  assign bits_o  = data_i << {off_i, 3'b000};

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = legal_o && (g >= int'(off_i)) && (g < int'(end_pos));
    assign bit_mask_o[8*g +: 8] = {8{lane_en}};
  end
endmodule

// File: rtl/disp_irq_core.sv
module disp_irq_core
  import disp_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             legal_i,
  input  logic [REG_W-1:0] bit_mask_i,
  input  logic [REG_W-1:0] bits_i,
  input  logic             vblank_i,
  output logic [REG_W-1:0] q_o,
  output logic             err_o
);
  logic [REG_W-1:0] q_d, rw_mask, ack_hit;

  assign rw_mask = bit_mask_i & ~(RO_MASK | ACK_MASK);
  assign ack_hit = bit_mask_i & bits_i & ACK_MASK;

  always_comb begin
    q_d = q_o;
    if (wr_en_i && legal_i) begin
      q_d = (q_o & ~rw_mask) | (bits_i & rw_mask);
      q_d = q_d & ~ack_hit;
    end
    if (vblank_i) q_d = q_d | ACK_MASK;  // hardware set beats acknowledge
    q_d[LIVE_B] = vblank_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      err_o <= 1'b0;
    end else begin
      q_o   <= q_d;
      err_o <= wr_en_i & ~legal_i;
    end
  end

  p_live_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_o[LIVE_B] == $past(vblank_i));
  p_vblank_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> (q_o[VB_FLG_B] && q_o[VL_FLG_B]));
  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && legal_i && !vblank_i && bit_mask_i[VB_FLG_B] && bits_i[VB_FLG_B])
    |=> !q_o[VB_FLG_B]);
  p_bad_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !legal_i) |=> (err_o && q_o[REG_W-1:5] == $past(q_o[REG_W-1:5])));
  p_no_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_i |-> bit_mask_i == '0);
endmodule

// File: rtl/disp_irq_gen.sv
module disp_irq_gen
  import disp_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] q_i,
  output logic             irq_o
);
  logic req;

  assign req = (q_i[VB_FLG_B] & q_i[VB_EN_B]) | (q_i[VL_FLG_B] & q_i[VL_EN_B]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= req;
  end

  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_i[VB_EN_B] && !q_i[VL_EN_B]) |=> !irq_o);
  p_irq_raise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_i[VB_FLG_B] && q_i[VB_EN_B]) |=> irq_o);
endmodule

// File: rtl/disp_irq_reg.sv
module disp_irq_reg
  import disp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              vblank_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              wr_err_o
);
  logic             legal;
  logic [REG_W-1:0] bit_mask, bits;

  disp_irq_merge u_merge (
    .off_i     (wr_off_i),
    .size_i    (wr_size_i),
    .data_i    (wr_data_i),
    .legal_o   (legal),
    .bit_mask_o(bit_mask),
    .bits_o    (bits)
  );

  disp_irq_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .legal_i   (legal),
    .bit_mask_i(bit_mask),
    .bits_i    (bits),
    .vblank_i  (vblank_i),
    .q_o       (rd_data_o),
    .err_o     (wr_err_o)
  );

  disp_irq_gen u_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .q_i   (rd_data_o),
    .irq_o (irq_o)
  );
endmodule

// File: tb/disp_irq_reg_tb.sv
module disp_irq_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_off_i = '0;
  logic [2:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        vblank_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o, wr_err_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] m_reg = '0;
  logic        m_irq = 1'b0, m_err = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  disp_irq_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_off_i(wr_off_i),
    .wr_size_i(wr_size_i), .wr_data_i(wr_data_i), .vblank_i(vblank_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o), .wr_err_o(wr_err_o)
  );

  // behavioural reference, stepped on each edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      logic [31:0] nxt;
      int sz, off;
      bit ok;
      nxt = m_reg;
      sz  = int'(wr_size_i);
      off = int'(wr_off_i);
      ok  = (sz == 1 || sz == 2 || sz == 4) && (off + sz <= 4);
      if (wr_en_i && ok) begin
        for (int b = 0; b < sz; b++) begin
          for (int i = 0; i < 8; i++) begin
            int p;
            logic v;
            p = 8 * (off + b) + i;
            v = wr_data_i[8 * b + i];
            if (p == 0) continue;
            if (p == 2 || p == 4) begin
              if (v) nxt[p] = 1'b0;
            end else nxt[p] = v;
          end
        end
      end
      if (vblank_i) begin
        nxt[2] = 1'b1;
        nxt[4] = 1'b1;
      end
      nxt[0] = vblank_i;
      m_irq  = (m_reg[2] & m_reg[1]) | (m_reg[4] & m_reg[3]);
      m_err  = wr_en_i && !ok;
      m_reg  = nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R1 live bit", 32'(rd_data_o[0]), 32'(m_reg[0]));
      chk("R2/R3 flags", {30'd0, rd_data_o[4], rd_data_o[2]}, {30'd0, m_reg[4], m_reg[2]});
      chk("R4/R5 stored bits", {rd_data_o[31:5], 1'b0, rd_data_o[3], rd_data_o[1], 2'b0},
          {m_reg[31:5], 1'b0, m_reg[3], m_reg[1], 2'b0});
      chk("R6 irq", 32'(irq_o), 32'(m_irq));
      chk("R7 error pulse", 32'(wr_err_o), 32'(m_err));
    end
  end

  task automatic wr(input int off, input int sz, input logic [31:0] d, input bit vb = 1'b0);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_off_i = 2'(off); wr_size_i = 3'(sz); wr_data_i = d; vblank_i = vb;
    @(negedge clk_i);
    wr_en_i = 1'b0; vblank_i = 1'b0;
  endtask

  task automatic idle(input int n, input bit vb = 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      vblank_i = vb;
    end
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (20000) @(posedge clk_i);
        fails++; tests++;
        $display("FAIL watchdog expired");
      end
      begin
        repeat (3) @(negedge clk_i);
        chk("R8 reset word", rd_data_o, 32'd0);
        chk("R8 reset irq", 32'(irq_o), 32'd0);
        chk("R8 reset err", 32'(wr_err_o), 32'd0);
        rst_ni = 1'b1;
        // R4 full word plain bits, R1 write to live bit ignored
        wr(0, 4, 32'hA5A5_5A4B);
        wr(0, 4, 32'h0000_0001);
        // R5 byte writes at each offset, halfword writes
        for (int k = 0; k < 4; k++) wr(k, 1, 32'h0000_00C3 + 32'(k));
        wr(2, 2, 32'h0000_BEEF);
        wr(0, 2, 32'h0000_1208);
        // R2 vblank sets flags, R6 irq with line-match enable
        idle(3, 1'b1);
        idle(3);
        // R3 ack line-match only
        wr(0, 1, 32'h0000_0018);
        // R3 ack into other lane leaves flags
        wr(1, 1, 32'h0000_0014);
        // R2 ack and vblank in same cycle: set wins
        wr(0, 1, 32'h0000_0014, 1'b1);
        wr(0, 1, 32'h0000_0016);
        // R6 enables off: no irq
        idle(2, 1'b1);
        wr(0, 1, 32'h0000_0000);
        idle(3);
        // R7 illegal accesses
        wr(3, 2, 32'hFFFF_FFFF);
        wr(2, 4, 32'hFFFF_FFFF);
        wr(0, 3, 32'hFFFF_FFFF);
        wr(0, 0, 32'hFFFF_FFFF);
        wr(1, 7, 32'hFFFF_FFFF);
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
          @(negedge clk_i);
          wr_en_i   = ($urandom % 2) == 0;
          wr_off_i  = 2'($urandom);
          wr_size_i = ($urandom % 8 == 0) ? 3'($urandom) : 3'(1 << ($urandom % 3));
          wr_data_i = $urandom;
          vblank_i  = ($urandom % 4) == 0;
        end
        @(negedge clk_i);
        wr_en_i = 1'b0; vblank_i = 1'b0;
        idle(3);
        disable watchdog;
      end
    join
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule